// File: doc/BRIEF.md
# Saturating Add/Subtract Unit

This block performs 32-bit signed addition and subtraction with saturation and produces five condition flags. One operation select picks among five forms. Two of them add: the second operand is a register value or a short immediate. Three of them subtract: the second operand from the first, the first from the second, or a long immediate from the second operand. A result that would overflow the signed range is clamped to the nearest representable extreme. The saturation flag is sticky: the caller supplies its current value, and the block returns it with saturation ORed in.

Operands enter on a valid/ready stream and leave on a second one. An input beat is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. An output beat is consumed on an edge where `out_valid` and `out_ready` are both high. With the default registered output, a result is presented on the cycle after its operands are accepted. It stays stable until it is consumed, and `in_ready` is high whenever the output slot is empty or is being drained. With the output register disabled, the path is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. Register-file access and instruction decode belong to the surrounding pipeline.

Top module: `sat_alu`

## Requirements
- R1: `in_op` selects the form. Code 0 gives dst+src. Code 1 gives dst+imm5. Code 2 gives dst−src. Code 3 gives src−dst. Code 4 gives src−imm16. Codes 5 to 7 behave as code 0.
- R2: The short immediate is `in_imm[4:0]` and the long immediate is `in_imm[15:0]`. Both are sign-extended to 32 bits. Immediate bits above the width used by the selected form have no effect.
- R3: If the exact signed result exceeds 0x7FFFFFFF, the result is 0x7FFFFFFF. If it is below −2^31, the result is 0x80000000. Otherwise the result is the exact value.
- R4: `out_ov` is 1 exactly when the result was clamped.
- R5: `out_sat` equals `in_sat` OR `out_ov` of the same operation, so arithmetic never clears it.
- R6: `out_s` is bit 31 of the delivered result, and `out_z` is 1 exactly when the delivered result is zero.
- R7: For additions, `out_cy` is the carry out of the unsigned 32-bit sum before clamping. For subtractions, it is the borrow, which is 1 when the minuend is below the subtrahend as unsigned numbers.
- R8: Every accepted input produces exactly one output, and outputs come in acceptance order. With the registered output, `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the result and the flags hold.
- R9: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0.
- R10: An operand that the selected form does not name has no effect on the outputs. This covers src for code 1, dst for code 4, and `in_imm` for codes 0, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Operand beat can be taken |
| in_op | input | 3 | Operation select |
| in_dst | input | 32 | Destination-register operand |
| in_src | input | 32 | Source-register operand |
| in_imm | input | 16 | Immediate field |
| in_sat | input | 1 | Current sticky saturation flag |
| out_valid | output | 1 | Result beat offered |
| out_ready | input | 1 | Consumer takes the result beat |
| out_res | output | 32 | Saturated result |
| out_cy | output | 1 | Carry or borrow of the unclamped operation |
| out_ov | output | 1 | Saturation occurred in this operation |
| out_s | output | 1 | Sign of the result |
| out_z | output | 1 | Result is zero |
| out_sat | output | 1 | Updated sticky saturation flag |

## Verification
The assertions check on every cycle that a clamped result carries one of the two extreme values and is never zero. They also check that saturation always implies the sticky flag. With the registered output, they check that a set `in_sat` on an accepted beat reappears on the next result, that a stalled result holds, that an empty output slot accepts input, and that nothing is valid right after reset. The arithmetic itself can only be shown by the bench's scenarios. These are the exact sums and differences for each form, the carry and borrow values, the sign-extension widths, the operands each form ignores, and in-order delivery under random back-pressure. The bench compares all of these against an independent model.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD_REG  = 3'd0,
    OP_ADD_SHRT = 3'd1,
    OP_SUB_REG  = 3'd2,
    OP_SUB_REV  = 3'd3,
    OP_SUB_LONG = 3'd4
  } sat_op_e;

  typedef struct packed {
    logic cy;
    logic ov;
    logic s;
    logic z;
    logic sat;
  } sat_flags_t;

  localparam int FLAG_BITS = 5;

endpackage

// File: rtl/sat_operand_sel.sv
module sat_operand_sel
  import sat_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_S = 5,
  parameter int IMM_L = 16
) (
  input  logic [2:0]       op,
  input  logic [W-1:0]     dst,
  input  logic [W-1:0]     src,
  input  logic [IMM_L-1:0] imm,
  output logic [W-1:0]     opa,
  output logic [W-1:0]     opb,
  output logic             subtract
);

  localparam int PAD_S = W - IMM_S;
  localparam int PAD_L = W - IMM_L;

  logic [W-1:0] imm_short_x;
  logic [W-1:0] imm_long_x;
  sat_op_e      op_e;

  assign imm_short_x = {{PAD_S{imm[IMM_S-1]}}, imm[IMM_S-1:0]};
  assign imm_long_x  = {{PAD_L{imm[IMM_L-1]}}, imm};
  assign op_e        = sat_op_e'(op);

  always_comb begin
    opa      = dst;
    opb      = src;
    subtract = 1'b0;
    case (op_e)
      OP_ADD_SHRT: begin
        opb = imm_short_x;
      end
      OP_SUB_REG: begin
        subtract = 1'b1;
      end
      OP_SUB_REV: begin
        opa      = src;
        opb      = dst;
        subtract = 1'b1;
      end
      OP_SUB_LONG: begin
        opa      = src;
        opb      = imm_long_x;
        subtract = 1'b1;
      end
      default: begin
        opa      = dst;
        opb      = src;
        subtract = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sat_addsub_core.sv
module sat_addsub_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         subtract,
  output logic [W-1:0] res,
  output logic         carry_flag,
  output logic         clamped
);

  localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] addend;
  logic [W:0]   wide;
  logic [W-1:0] raw;
  logic         addend_sign;

  // Subtraction as a + ~b + 1, so the carry out is the inverted borrow.
  assign addend      = subtract ? ~opb : opb;
  assign wide        = {1'b0, opa} + {1'b0, addend} + {{W{1'b0}}, subtract};
  assign raw         = wide[W-1:0];
  assign addend_sign = addend[W-1];

  assign carry_flag = subtract ? ~wide[W] : wide[W];
  assign clamped    = (opa[W-1] == addend_sign) && (raw[W-1] != opa[W-1]);

  always_comb begin
    if (!clamped)       res = raw;
    else if (opa[W-1])  res = NEG_LIMIT;
    else                res = POS_LIMIT;
  end

endmodule

// File: rtl/sat_flag_gen.sv
module sat_flag_gen
  import sat_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  logic         carry_flag,
  input  logic         clamped,
  input  logic         sat_prev,
  output sat_flags_t   flags
);

  always_comb begin
    flags.cy  = carry_flag;
    flags.ov  = clamped;
    flags.s   = res[W-1];
    flags.z   = (res == '0);
    flags.sat = sat_prev | clamped;
  end

endmodule

// File: rtl/sat_out_stage.sv
module sat_out_stage #(
  parameter int DW      = 37,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [DW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [DW-1:0] dn_data
);

  generate
    if (REG_OUT) begin : g_reg
      logic          vld_q;
      logic [DW-1:0] data_q;

      assign up_ready = !vld_q || dn_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
        end else if (up_ready) begin
          vld_q <= up_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (up_ready && up_valid) data_q <= up_data;
      end

      assign dn_valid = vld_q;
      assign dn_data  = data_q;
    end else begin : g_pass
      logic unused_pass;
      assign unused_pass = clk ^ rst_n;
      assign up_ready    = dn_ready;
      assign dn_valid    = up_valid;
      assign dn_data     = up_data;
    end
  endgenerate

endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int W       = 32,
  parameter int IMM_S   = 5,
  parameter int IMM_L   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [W-1:0]     in_dst,
  input  logic [W-1:0]     in_src,
  input  logic [IMM_L-1:0] in_imm,
  input  logic             in_sat,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_res,
  output logic             out_cy,
  output logic             out_ov,
  output logic             out_s,
  output logic             out_z,
  output logic             out_sat
);

  localparam int DW = W + FLAG_BITS;

  logic [W-1:0]  opa, opb, res;
  logic          subtract, carry_flag, clamped;
  sat_flags_t    flags, flags_o;
  logic [DW-1:0] pay_in, pay_out;

  sat_operand_sel #(.W(W), .IMM_S(IMM_S), .IMM_L(IMM_L)) u_sel (
    .op       (in_op),
    .dst      (in_dst),
    .src      (in_src),
    .imm      (in_imm),
    .opa      (opa),
    .opb      (opb),
    .subtract (subtract)
  );

  sat_addsub_core #(.W(W)) u_core (
    .opa        (opa),
    .opb        (opb),
    .subtract   (subtract),
    .res        (res),
    .carry_flag (carry_flag),
    .clamped    (clamped)
  );

  sat_flag_gen #(.W(W)) u_flags (
    .res        (res),
    .carry_flag (carry_flag),
    .clamped    (clamped),
    .sat_prev   (in_sat),
    .flags      (flags)
  );

  assign pay_in = {res, flags};

  sat_out_stage #(.DW(DW), .REG_OUT(REG_OUT)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (pay_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_out)
  );

  assign out_res = pay_out[DW-1:FLAG_BITS];
  assign flags_o = pay_out[FLAG_BITS-1:0];
  assign out_cy  = flags_o.cy;
  assign out_ov  = flags_o.ov;
  assign out_s   = flags_o.s;
  assign out_z   = flags_o.z;
  assign out_sat = flags_o.sat;

endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_sat,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_res,
  input logic         out_cy,
  input logic         out_ov,
  input logic         out_s,
  input logic         out_z,
  input logic         out_sat
);

  localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

  assert_clamp_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ov |-> (out_res == POS_LIMIT) || (out_res == NEG_LIMIT));

  assert_clamp_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ov |-> !out_z);

  assert_ov_sets_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ov |-> out_sat);

  generate
    if (REG_OUT) begin : g_reg_chk
      assert_sticky_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_sat |=> out_sat);

      assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_cy)
          && $stable(out_ov) && $stable(out_s) && $stable(out_z) && $stable(out_sat));

      assert_empty_accepts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

      assert_reset_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !out_valid);
    end
  endgenerate

endmodule

bind sat_alu sat_alu_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sat    (in_sat),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_res   (out_res),
  .out_cy    (out_cy),
  .out_ov    (out_ov),
  .out_s     (out_s),
  .out_z     (out_z),
  .out_sat   (out_sat)
);

// File: tb/tb_sat_alu.sv
`timescale 1ns/1ps
module tb_sat_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [31:0] in_dst = '0, in_src = '0;
  logic [15:0] in_imm = '0;
  logic        in_sat = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_res;
  logic        out_cy, out_ov, out_s, out_z, out_sat;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sat_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm),
    .in_sat(in_sat), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_cy(out_cy), .out_ov(out_ov), .out_s(out_s),
    .out_z(out_z), .out_sat(out_sat)
  );

  // Expected beat: {res[31:0], cy, ov, s, z, sat}
  logic [36:0] exp_q[$];

  function automatic logic [36:0] model(input logic [2:0] op, input logic [31:0] d,
                                        input logic [31:0] s, input logic [15:0] im,
                                        input logic si);
    logic [31:0] a, b, r;
    logic [32:0] u;
    bit sub, ov, cy;
    longint ex;
    case (op)
      3'd1: begin a = d; b = {{27{im[4]}}, im[4:0]}; sub = 0; end
      3'd2: begin a = d; b = s; sub = 1; end
      3'd3: begin a = s; b = d; sub = 1; end
      3'd4: begin a = s; b = {{16{im[15]}}, im}; sub = 1; end
      default: begin a = d; b = s; sub = 0; end
    endcase
    if (sub) begin
      ex = longint'($signed(a)) - longint'($signed(b));
      cy = (a < b);
    end else begin
      ex = longint'($signed(a)) + longint'($signed(b));
      u  = {1'b0, a} + {1'b0, b};
      cy = u[32];
    end
    ov = 0;
    if (ex > 64'sd2147483647) begin r = 32'h7FFFFFFF; ov = 1; end
    else if (ex < -64'sd2147483648) begin r = 32'h80000000; ov = 1; end
    else r = ex[31:0];
    return {r, cy, ov, r[31], (r == 32'h0), si | ov};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", what, act, expv, $time);
    end
  endtask

  function automatic logic [31:0] pick(input int k);
    case (k)
      0: return 32'h7FFFFFFF;
      1: return 32'h80000000;
      2: return 32'h00000000;
      3: return 32'hFFFFFFFF;
      4: return 32'h00000001;
      default: return $urandom;
    endcase
  endfunction

  localparam int NDIR = 12;
  localparam int NTOT = 1500;

  task automatic load_stim(input int idx);
    case (idx)
      0:  begin in_op = 0; in_dst = 32'h7FFFFFFF; in_src = 1;            in_imm = 16'h1234; in_sat = 0; end
      1:  begin in_op = 0; in_dst = 32'h80000000; in_src = 32'hFFFFFFFF; in_imm = 16'h0;    in_sat = 0; end
      2:  begin in_op = 1; in_dst = 0;            in_src = 32'hDEADBEEF; in_imm = 16'hABFF; in_sat = 0; end
      3:  begin in_op = 1; in_dst = 32'h7FFFFFF0; in_src = 0;            in_imm = 16'h000F; in_sat = 0; end
      4:  begin in_op = 2; in_dst = 32'h80000000; in_src = 1;            in_imm = 16'hFFFF; in_sat = 0; end
      5:  begin in_op = 3; in_dst = 7;            in_src = 5;            in_imm = 16'h5555; in_sat = 0; end
      6:  begin in_op = 4; in_dst = 32'h12345678; in_src = 0;            in_imm = 16'h8000; in_sat = 0; end
      7:  begin in_op = 4; in_dst = 0;            in_src = 32'h80000000; in_imm = 16'h0001; in_sat = 0; end
      8:  begin in_op = 0; in_dst = 5;            in_src = 32'hFFFFFFFB; in_imm = 16'h0;    in_sat = 0; end
      9:  begin in_op = 2; in_dst = 3;            in_src = 3;            in_imm = 16'h0;    in_sat = 1; end
      10: begin in_op = 6; in_dst = 32'h40000000; in_src = 32'h40000000; in_imm = 16'hFFFF; in_sat = 0; end
      11: begin in_op = 3; in_dst = 32'h80000000; in_src = 0;            in_imm = 16'h0;    in_sat = 1; end
      default: begin
        in_op  = 3'($urandom_range(0, 7));
        in_dst = pick($urandom_range(0, 9));
        in_src = pick($urandom_range(0, 9));
        in_imm = 16'($urandom);
        in_sat = 1'($urandom_range(0, 1));
      end
    endcase
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [36:0] e;
    logic [36:0] act;
    logic [36:0] held;
    bit stalled = 0;
    bit took = 0;
    int idx = 0;

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid during reset", 32'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R9 out_valid after reset", 32'(out_valid), 0);

    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      act = {out_res, out_cy, out_ov, out_s, out_z, out_sat};
      if (stalled)
        chk(out_valid && act == held, "R8 stalled beat held", act[36:5], held[36:5]);
      if (!in_valid || took) begin
        if (idx < NTOT && (idx < NDIR || $urandom_range(0, 4) != 0)) begin
          load_stim(idx);
          in_valid = 1'b1;
          idx++;
        end else begin
          in_valid = 1'b0;
        end
      end
      out_ready = (idx <= NDIR || idx >= NTOT) ? 1'b1 : ($urandom_range(0, 9) < 7);
      #1;
      chk(in_ready == (!out_valid || out_ready), "R8 ready rule", 32'(in_ready),
          32'(!out_valid || out_ready));
      took = in_valid && in_ready;
      if (took) exp_q.push_back(model(in_op, in_dst, in_src, in_imm, in_sat));
      act = {out_res, out_cy, out_ov, out_s, out_z, out_sat};
      stalled = out_valid && !out_ready;
      held = act;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8 output without accepted input", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(act[36:5] == e[36:5], "R1 R2 R3 R10 result", act[36:5], e[36:5]);
          chk(act[4] == e[4], "R7 carry/borrow", 32'(act[4]), 32'(e[4]));
          chk(act[3] == e[3], "R4 ov", 32'(act[3]), 32'(e[3]));
          chk(act[2] == e[2], "R6 sign", 32'(act[2]), 32'(e[2]));
          chk(act[1] == e[1], "R6 zero", 32'(act[1]), 32'(e[1]));
          chk(act[0] == e[0], "R5 sticky sat", 32'(act[0]), 32'(e[0]));
        end
      end
      if (idx >= NTOT && !in_valid && exp_q.size() == 0 && !out_valid) break;
    end
    chk(exp_q.size() == 0, "R8 all accepted beats delivered", exp_q.size(), 0);
    chk(idx == NTOT, "R8 all stimulus accepted", idx, NTOT);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule